// File: doc/BRIEF.md
# Block-Read DMA Controller

This peripheral lets software fetch one sector of storage into main memory without moving any data word itself. Software writes a logical block number and a destination byte address into the controller's registers. It then writes a start command. The controller turns the logical block number into a physical position made of a cylinder, a surface and a sector. It presents that position on a request port for one cycle to a sector source.

The sector source then streams the sector's words over a valid/ready handshake. The controller forwards each word to a memory write port at consecutive word addresses. After the last word it drops busy and raises an interrupt. The interrupt stays up until software reads the status register or writes 1 to its done bit.

Geometry is set by parameters: sectors per track, surfaces, reserved leading cylinders and words per sector. Each track index fills every surface of a cylinder before the cylinder number advances. The cylinder number is shifted past the reserved cylinders.

Top module: `blkrd_dma`

## Requirements
- R1: After reset the status word is zero, `irq` is 0, `sec_req` is 0 and `mem_wr_valid` is 0.
- R2: A register write to offset 0 with bit 0 set, while idle, starts a transfer. In the next cycle status bit 0 (busy) is 1 and `sec_req` is high for exactly one cycle. A write to offset 0 with bit 0 clear does nothing.
- R3: For logical block L, with S sectors per track, H surfaces and C reserved cylinders, the physical position is sector = L mod S, surface = (L div S) mod H and cylinder = (L div S) div H + C. It appears on `sec_sect`, `sec_head` and `sec_cyl` while `sec_req` is high. It also reads back at offset 4 with the sector in bits 7:0, the surface in bits 15:8 and the cylinder in bits 31:16.
- R4: A transfer performs exactly SECT_WORDS memory writes. Write i goes to address D + i*(DW/8), where D is the value at offset 2 when the command was accepted. It carries the i-th word accepted from the source.
- R5: A word moves only in a cycle where both `src_valid` and `mem_wr_ready` are high. `mem_wr_valid` is never high without `src_valid`, and `src_ready` is never high without `mem_wr_ready`.
- R6: In the cycle after the last word is accepted, busy is 0 and status bit 1 (done) and `irq` are both 1.
- R7: `irq` follows done. It stays high until a register read of offset 3, or a write to offset 3 with bit 1 set, clears it. A completion in the same cycle as a clear wins.
- R8: A start command while busy is ignored. No new request is issued and the running transfer keeps its original block and destination. Status bit 2 (error) is set and stays set until a write to offset 3 with bit 2 set.
- R9: Register offsets are 1 for the block number, 2 for the destination and 3 for status. Offset 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on status) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt, level |
| sec_req | output | 1 | One-cycle sector request |
| sec_cyl | output | LBN_W | Requested cylinder |
| sec_head | output | clog2(SURF) | Requested surface |
| sec_sect | output | clog2(SPT) | Requested sector |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Controller accepts source word |
| src_data | input | DW | Source word |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts write |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | DW | Memory write data |

## Verification
The properties assume the sector source offers words only after a request and keeps them coming until a full sector has been delivered. They also assume memory eventually accepts every write. A stalled or short sector would leave the controller busy indefinitely rather than break any property. The stimulus meets these assumptions with a source model that counts the words it has handed over and stops at one sector. Its stall patterns on `src_valid` and `mem_wr_ready` are periodic, so every transfer ends. Software-side accesses are kept to one register operation per cycle, and reads with side effects occur only at offset 3.

// File: rtl/blkrd_pkg.sv
// Package: shared state encoding and register offsets for the block-read DMA.
// Assumes a 3-bit word-offset register bus, 32 bits wide.
package blkrd_pkg;
    localparam int unsigned REG_W = 32;

    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_LBN  = 3'd1;
    localparam logic [2:0] OFS_DEST = 3'd2;
    localparam logic [2:0] OFS_STAT = 3'd3;
    localparam logic [2:0] OFS_PHYS = 3'd4;

    localparam int unsigned ST_BUSY = 0;
    localparam int unsigned ST_DONE = 1;
    localparam int unsigned ST_ERR  = 2;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_REQ  = 2'd1,
        MV_XFER = 2'd2
    } mv_state_t;
endpackage

// File: rtl/blkrd_xlate.sv
// Module: converts a logical block number into cylinder/surface/sector and
// holds the result from the start command until the next one.
// Assumes constant divisors (SPT, SURF >= 2) so division reduces to constants.
module blkrd_xlate #(
    parameter int LBN_W     = 16,
    parameter int SPT       = 5,
    parameter int SURF      = 3,
    parameter int SPARE_CYL = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LBN_W-1:0]         lbn,
    output logic [$clog2(SPT)-1:0]   sect_q,
    output logic [$clog2(SURF)-1:0]  surf_q,
    output logic [LBN_W-1:0]         cyl_q
);
    localparam int SECT_W = $clog2(SPT);
    localparam int SURF_W = $clog2(SURF);
    localparam logic [LBN_W-1:0] SPT_V   = LBN_W'(SPT);
    localparam logic [LBN_W-1:0] SURF_V  = LBN_W'(SURF);
    localparam logic [LBN_W-1:0] SPARE_V = LBN_W'(SPARE_CYL);

    logic [LBN_W-1:0] track;
    logic [SECT_W-1:0] sect_d;
    logic [SURF_W-1:0] surf_d;
    logic [LBN_W-1:0]  cyl_d;

    // Purpose: split block number into track and sector, track into cylinder and surface.
    always_comb begin
        track  = lbn / SPT_V;
        sect_d = SECT_W'(lbn % SPT_V);
        surf_d = SURF_W'(track % SURF_V);
        cyl_d  = (track / SURF_V) + SPARE_V;
    end

    // Purpose: capture the physical position when a transfer is started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q <= '0;
            surf_q <= '0;
            cyl_q  <= '0;
        end else if (load) begin
            sect_q <= sect_d;
            surf_q <= surf_d;
            cyl_q  <= cyl_d;
        end
    end
endmodule

// File: rtl/blkrd_regs.sv
// Module: software-visible registers: block number, destination, command
// decode, status flags and interrupt. Assumes one access per cycle.
module blkrd_regs
    import blkrd_pkg::*;
#(
    parameter int LBN_W = 16,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             fin,
    input  logic [REG_W-1:0] phys_word,
    output logic [LBN_W-1:0] lbn_q,
    output logic [AW-1:0]    dest_q,
    output logic             start,
    output logic             irq
);
    logic done_q, err_q;
    logic cmd_go, stat_wr, stat_rd;

    // Purpose: decode command and status accesses.
    always_comb begin
        cmd_go  = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[0];
        stat_wr = reg_wr && (reg_addr == OFS_STAT);
        stat_rd = reg_rd && (reg_addr == OFS_STAT);
        start   = cmd_go && !busy;
    end

    // Purpose: hold block number and destination written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lbn_q  <= '0;
            dest_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_LBN)  lbn_q  <= reg_wdata[LBN_W-1:0];
            if (reg_addr == OFS_DEST) dest_q <= reg_wdata[AW-1:0];
        end
    end

    // Purpose: done flag, set on completion (priority) and cleared by read or write-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   done_q <= 1'b0;
        else if (fin)                                 done_q <= 1'b1;
        else if (stat_rd || (stat_wr && reg_wdata[ST_DONE])) done_q <= 1'b0;
    end

    // Purpose: error flag, set by a command while busy, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   err_q <= 1'b0;
        else if (cmd_go && busy)                      err_q <= 1'b1;
        else if (stat_wr && reg_wdata[ST_ERR])        err_q <= 1'b0;
    end

    assign irq = done_q;

    // Purpose: read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_LBN:  reg_rdata = REG_W'(lbn_q);
            OFS_DEST: reg_rdata = REG_W'(dest_q);
            OFS_STAT: begin
                reg_rdata[ST_BUSY] = busy;
                reg_rdata[ST_DONE] = done_q;
                reg_rdata[ST_ERR]  = err_q;
            end
            OFS_PHYS: reg_rdata = phys_word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/blkrd_mover.sv
// Module: transfer sequencer. Issues one sector request, then forwards
// SECT_WORDS source words to memory at incrementing addresses.
// Assumes SECT_WORDS >= 2 and that the source delivers a full sector.
module blkrd_mover
    import blkrd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int SECT_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] dest,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    input  logic          mem_wr_ready,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic          sec_req,
    output logic          busy,
    output logic          fin
);
    localparam int CNT_W = $clog2(SECT_WORDS);
    localparam logic [AW-1:0]    STEP = AW'(DW / 8);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SECT_WORDS - 1);

    mv_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    addr;
    logic             beat;

    // Purpose: handshake and status outputs derived from the state.
    always_comb begin
        beat         = (state == MV_XFER) && src_valid && mem_wr_ready;
        busy         = (state != MV_IDLE);
        sec_req      = (state == MV_REQ);
        src_ready    = (state == MV_XFER) && mem_wr_ready;
        mem_wr_valid = (state == MV_XFER) && src_valid;
        mem_wr_addr  = addr;
        mem_wr_data  = src_data;
        fin          = beat && (cnt == LAST);
    end

    // Purpose: sequence idle -> request -> transfer and step the address and word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MV_IDLE;
            cnt   <= '0;
            addr  <= '0;
        end else begin
            case (state)
                MV_IDLE: if (start) begin
                    state <= MV_REQ;
                    cnt   <= '0;
                    addr  <= dest;
                end
                MV_REQ: state <= MV_XFER;
                MV_XFER: if (beat) begin
                    addr <= addr + STEP;
                    cnt  <= cnt + 1'b1;
                    if (cnt == LAST) state <= MV_IDLE;
                end
                default: state <= MV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blkrd_dma.sv
// Module: top of the block-read DMA controller. Wires registers, translator
// and mover; packs the physical position for software readback.
module blkrd_dma #(
    parameter int LBN_W      = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int SPT        = 5,
    parameter int SURF       = 3,
    parameter int SPARE_CYL  = 2,
    parameter int SECT_WORDS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [2:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    irq,
    output logic                    sec_req,
    output logic [LBN_W-1:0]        sec_cyl,
    output logic [$clog2(SURF)-1:0] sec_head,
    output logic [$clog2(SPT)-1:0]  sec_sect,
    input  logic                    src_valid,
    output logic                    src_ready,
    input  logic [DW-1:0]           src_data,
    output logic                    mem_wr_valid,
    input  logic                    mem_wr_ready,
    output logic [AW-1:0]           mem_wr_addr,
    output logic [DW-1:0]           mem_wr_data
);
    logic             busy, fin, start;
    logic [LBN_W-1:0] lbn_q;
    logic [AW-1:0]    dest_q;
    logic [31:0]      phys_word;

    // Purpose: pack cylinder, surface and sector into the readback word.
    assign phys_word = {16'(sec_cyl), 8'(sec_head), 8'(sec_sect)};

    blkrd_regs #(.LBN_W(LBN_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .fin(fin), .phys_word(phys_word),
        .lbn_q(lbn_q), .dest_q(dest_q), .start(start), .irq(irq)
    );

    blkrd_xlate #(.LBN_W(LBN_W), .SPT(SPT), .SURF(SURF), .SPARE_CYL(SPARE_CYL)) u_xlate (
        .clk(clk), .rst_n(rst_n), .load(start), .lbn(lbn_q),
        .sect_q(sec_sect), .surf_q(sec_head), .cyl_q(sec_cyl)
    );

    blkrd_mover #(.AW(AW), .DW(DW), .SECT_WORDS(SECT_WORDS)) u_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .dest(dest_q),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .mem_wr_ready(mem_wr_ready), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .sec_req(sec_req), .busy(busy), .fin(fin)
    );
endmodule

// File: rtl/blkrd_chk.sv
// Module: property checker for blkrd_dma, attached by bind.
// Assumes the register bus issues at most one access per cycle.
module blkrd_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          irq,
    input logic          sec_req,
    input logic          src_valid,
    input logic          src_ready,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_wr_addr,
    input logic          busy
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |=> !sec_req); // R2
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[0] && !busy)); // R2
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> src_valid); // R5
    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |-> (mem_wr_valid && mem_wr_ready)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && $past(mem_wr_valid && mem_wr_ready))
            |-> mem_wr_addr == $past(mem_wr_addr) + STEP); // R4
    AST_FIN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_rd && reg_addr == 3'd3) && !(reg_wr && reg_addr == 3'd3 && reg_wdata[1]))
            |=> irq); // R7
    AST_BUSY_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 3'd0) |=> !sec_req); // R8
endmodule

bind blkrd_dma blkrd_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .sec_req(sec_req),
    .src_valid(src_valid), .src_ready(src_ready), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .busy(busy)
);

// File: tb/sim_blkrd_dma.sv
// Bench: sweeps logical blocks 0..29 with varied stall patterns and checks
// translation, write stream, completion, interrupt clearing and busy rejects.
module sim_blkrd_dma;
    localparam int SPT = 5, SURF = 3, SPARE = 2, NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sec_req, src_ready, mem_wr_valid;
    logic [15:0] sec_cyl;
    logic [1:0]  sec_head;
    logic [2:0]  sec_sect;
    logic        src_valid = 1'b0, mem_wr_ready = 1'b0;
    logic [31:0] src_data = '0;
    logic [31:0] mem_wr_addr, mem_wr_data;

    int checks = 0, failures = 0;
    int exp_lbn = 0, mode = 0, src_idx = NW, wcnt = 0, req_cnt = 0, cyc = 0;
    logic [31:0] exp_dest = '0;
    logic finished = 1'b0;

    blkrd_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sec_req(sec_req), .sec_cyl(sec_cyl), .sec_head(sec_head),
        .sec_sect(sec_sect), .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] wval(int l, int i);
        return {l[15:0], 8'hA5, i[7:0]};
    endfunction

    function automatic logic [31:0] phys_of(int l);
        int trk;
        trk = l / SPT;
        return {16'(trk / SURF + SPARE), 8'(trk % SURF), 8'(l % SPT)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: request, handshake and memory writes at the clock edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (sec_req) begin
                req_cnt++;
                chk("R3 req position", {16'(sec_cyl), 8'(sec_head), 8'(sec_sect)}, phys_of(exp_lbn));
            end
            if ((src_valid && src_ready) != (mem_wr_valid && mem_wr_ready))
                chk("R5 handshake pairing", 32'(src_valid && src_ready), 32'(mem_wr_valid && mem_wr_ready));
            if (src_valid && src_ready) src_idx++;
            if (mem_wr_valid && mem_wr_ready) begin
                chk("R4 write addr", mem_wr_addr, exp_dest + 32'(4 * wcnt));
                chk("R4 write data", mem_wr_data, wval(exp_lbn, wcnt));
                wcnt++;
            end
        end
    end

    // Source and memory models with per-transfer stall patterns.
    always @(negedge clk) begin
        cyc++;
        case (mode)
            0: begin src_valid = (src_idx < NW); mem_wr_ready = 1'b1; end
            1: begin src_valid = (src_idx < NW) && (cyc % 3 != 0); mem_wr_ready = 1'b1; end
            2: begin src_valid = (src_idx < NW); mem_wr_ready = (cyc % 2 == 0); end
            default: begin src_valid = (src_idx < NW) && (cyc % 3 != 1); mem_wr_ready = (cyc % 4 != 0); end
        endcase
        src_data = wval(exp_lbn, src_idx);
    end

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic run_xfer(int l, bit poke);
        logic [31:0] v;
        int n;
        exp_lbn = l; mode = l % 4; exp_dest = 32'h1000 + 32'(l * 64);
        wcnt = 0; req_cnt = 0; src_idx = 0;
        wreg(3'd1, 32'(l));
        wreg(3'd2, exp_dest);
        wreg(3'd0, 32'h1);
        peek(3'd3, v);
        chk("R2 busy after start", v & 32'h1, 32'h1);
        chk("R2 request high", 32'(sec_req), 32'h1);
        if (poke) begin
            @(negedge clk);
            wreg(3'd2, 32'hDEAD0000);
            wreg(3'd0, 32'h1);
            peek(3'd3, v);
            chk("R8 error set", v & 32'h5, 32'h5);
        end
        n = 0;
        while (!irq && n < 300) begin @(negedge clk); n++; end
        peek(3'd3, v);
        chk("R6 busy low done high", v & 32'h3, 32'h2);
        chk("R4 word count", 32'(wcnt), 32'(NW));
        chk("R8 single request", 32'(req_cnt), 32'h1);
        peek(3'd4, v);
        chk("R3 readback", v, phys_of(l));
        repeat (3) @(negedge clk);
        chk("R7 irq held", 32'(irq), 32'h1);
        if (l % 2 == 0) begin
            @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd3;
            @(negedge clk); reg_rd = 1'b0;
        end else begin
            wreg(3'd3, 32'h2);
        end
        chk("R7 irq cleared", 32'(irq), 32'h0);
        if (poke) begin
            peek(3'd3, v);
            chk("R8 error kept", v & 32'h4, 32'h4);
            wreg(3'd3, 32'h4);
            peek(3'd3, v);
            chk("R8 error cleared", v, 32'h0);
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(3'd3, v);
        chk("R1 status", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 request", 32'(sec_req), 32'h0);
        chk("R1 write valid", 32'(mem_wr_valid), 32'h0);
        wreg(3'd0, 32'h0);
        peek(3'd3, v);
        chk("R2 bit0 clear ignored", v, 32'h0);
        wreg(3'd1, 32'h1234);
        wreg(3'd2, 32'h0000_ABC0);
        peek(3'd1, v); chk("R9 lbn readback", v, 32'h1234);
        peek(3'd2, v); chk("R9 dest readback", v, 32'h0000_ABC0);
        peek(3'd0, v); chk("R9 cmd reads zero", v, 32'h0);
        for (int l = 0; l < 30; l++) run_xfer(l, (l % 7 == 3));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule